// File: doc/BRIEF.md
# Settling-Time Sweep Self-Test Sequencer

This block drives an equivalent-time measurement of how an ADC input driver settles after a voltage step. Each conversion follows the same sequence. The analog multiplexer is first held on its grounded input for a programmable dwell, so that the ADC sampling capacitor can discharge. The multiplexer then switches to the DC-voltage input, which creates the step. After a programmable edge offset, counted in clock cycles, the block pulses the ADC convert strobe and waits for the conversion result.

Each edge offset is repeated 4^w times, and the 16-bit codes are summed into a 16+2w bit accumulator. The sum is shifted right by w bits and written to a result memory. The stored word therefore carries w fractional bits below the ADC's own resolution.

The first point uses the programmed start offset, which is the late instant. Each later point moves the edge earlier by the programmed step. The sweep always ends with a point at offset zero, which is the instant the multiplexer switches. One cycle after the final write, a single-cycle done pulse marks the end of the sweep. If a conversion result never arrives, a timeout ends the sweep and raises an error flag.

Top module: `settle_sweep_bist`

## Requirements
- R1: After reset, busy, done, err, res_we, adc_convst and mux_sel are all 0 (mux_sel 0 selects the grounded input, 1 selects the voltage input).
- R2: A one-cycle start while idle captures cfg_start_ofs, cfg_step and cfg_dwell, and busy reads 1 from the following cycle.
- R3: Before every convert, mux_sel is 0 for at least cfg_dwell+1 consecutive cycles and then rises. It stays 1 through the convert pulse and the wait for data. adc_convst is a one-cycle pulse and occurs only while mux_sel is 1.
- R4: adc_convst rises exactly offset+1 clock cycles after the mux_sel rise that precedes it, where offset is the current point's edge offset.
- R5: Each point takes exactly 4^EXTRA_W accepted conversions. The written res_data, of width 16+EXTRA_W, equals the sum of their adc_data codes shifted right by EXTRA_W.
- R6: Point k is written at res_addr k, starting from 0. Point 0 uses offset cfg_start_ofs. Each following offset is the previous offset minus the step, or 0 when the previous offset is smaller than the step. The point at offset 0 is the last one. A step of 0 acts as a step of 1.
- R7: done is high for exactly one cycle, the cycle right after the last res_we. busy is 0 from the next cycle.
- R8: While busy, changes on the configuration inputs and further start pulses have no effect on the sweep in progress.
- R9: If no adc_valid arrives within TIMEOUT_CYC cycles after a convert pulse, that point is not written. err is then set, and the sweep ends with a done pulse. err stays 1 until the next start clears it.
- R10: adc_valid asserted outside the wait that follows a convert pulse is ignored. It adds nothing to any sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one cycle is one delay unit |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a sweep when idle |
| cfg_start_ofs | input | DLY_W | Edge offset of the first (latest) point, in cycles |
| cfg_step | input | DLY_W | Offset decrement between points (0 acts as 1) |
| cfg_dwell | input | DLY_W | Grounded-input dwell before each step, in cycles minus one |
| adc_data | input | DATA_W | Conversion code, unsigned |
| adc_valid | input | 1 | adc_data is valid this cycle |
| mux_sel | output | 1 | 0 selects the grounded input, 1 selects the voltage input |
| adc_convst | output | 1 | One-cycle convert strobe |
| res_we | output | 1 | Result write enable |
| res_addr | output | ADDR_W | Result index (point number) |
| res_data | output | DATA_W+EXTRA_W | Averaged code with EXTRA_W fractional bits |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| err | output | 1 | Sweep ended by a data timeout |

## Verification
The bound checker watches several properties on every cycle: the convert strobe is a single cycle, it falls inside the voltage-input window, and that window stays open into the data wait. It also checks that done is a lone pulse followed by idle, that result addresses rise by one within a sweep, that nothing is written once an error has been raised, and that an idle block is quiet. The bench scenarios are needed for the quantities that depend on configuration or data. These are the exact gap from step to convert for each point, the dwell length, the offset sequence and point count for several start/step pairs including a zero step, and the averaged value. They also cover the blocking of configuration changes and of stray valid strobes, and the timeout path together with its error flag.

// File: rtl/settle_sweep_pkg.sv
// Shared types for the settling-time sweep sequencer.
// Assumes: single clock domain, one sweep at a time.
package settle_sweep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GND    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_CONV   = 3'd3,
        ST_DATA   = 3'd4,
        ST_WRITE  = 3'd5,
        ST_FINISH = 3'd6
    } sweep_st_t;
endpackage

// File: rtl/settle_timer.sv
// Phase timer: counts cycles from the last clear and flags when the count
// equals the supplied limit. Assumes the owner clears it on every phase change.
module settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    // Count up, restart from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // Terminal compare against the phase limit.
    always_comb hit = (cnt == limit);
endmodule

// File: rtl/settle_accum.sv
// Repetition accumulator: sums 4^EXTRA_W codes per point, counts repetitions,
// and presents the sum shifted right by EXTRA_W. Assumes EXTRA_W >= 1.
module settle_accum #(
    parameter int DATA_W  = 16,
    parameter int EXTRA_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      add,
    input  logic [DATA_W-1:0]         din,
    output logic                      last_rep,
    output logic [DATA_W+EXTRA_W-1:0] avg
);
    localparam int REP_W = 2 * EXTRA_W;
    localparam int ACC_W = DATA_W + REP_W;

    logic [ACC_W-1:0] acc;
    logic [REP_W-1:0] rep;

    // Sum accepted codes; clear between points.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (add)      acc <= acc + {{REP_W{1'b0}}, din};
    end

    // Count accepted conversions within the point.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) rep <= '0;
        else if (add)      rep <= rep + 1'b1;
    end

    // Last repetition is the all-ones count; average keeps EXTRA_W fraction bits.
    always_comb begin
        last_rep = &rep;
        avg      = acc[ACC_W-1:EXTRA_W];
    end
endmodule

// File: rtl/settle_ofs_gen.sv
// Edge-offset generator: holds the current offset and point index, steps the
// offset down (clamped at zero) on advance. A zero step is treated as one.
module settle_ofs_gen #(
    parameter int DLY_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [DLY_W-1:0]  cfg_ofs,
    input  logic [DLY_W-1:0]  cfg_step,
    output logic [DLY_W-1:0]  ofs,
    output logic [ADDR_W-1:0] idx,
    output logic              at_zero
);
    logic [DLY_W-1:0] step_q;

    // Latch configuration on load, step down on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs    <= '0;
            step_q <= '0;
            idx    <= '0;
        end else if (load) begin
            ofs    <= cfg_ofs;
            step_q <= (cfg_step == '0) ? DLY_W'(1) : cfg_step;
            idx    <= '0;
        end else if (adv) begin
            ofs    <= (ofs >= step_q) ? (ofs - step_q) : '0;
            idx    <= idx + 1'b1;
        end
    end

    // Final point is reached when the offset is the step instant itself.
    always_comb at_zero = (ofs == '0);
endmodule

// File: rtl/settle_sweep_bist.sv
// Settling-time sweep sequencer top. Per conversion: ground dwell, switch to
// the voltage input, wait the edge offset, pulse convert, wait for data.
// Assumes TIMEOUT_CYC fits in DLY_W bits and the ADC answers one strobe at a time.
module settle_sweep_bist
    import settle_sweep_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int EXTRA_W     = 4,
    parameter int DLY_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [DLY_W-1:0]          cfg_start_ofs,
    input  logic [DLY_W-1:0]          cfg_step,
    input  logic [DLY_W-1:0]          cfg_dwell,
    input  logic [DATA_W-1:0]         adc_data,
    input  logic                      adc_valid,
    output logic                      mux_sel,
    output logic                      adc_convst,
    output logic                      res_we,
    output logic [ADDR_W-1:0]         res_addr,
    output logic [DATA_W+EXTRA_W-1:0] res_data,
    output logic                      busy,
    output logic                      done,
    output logic                      err
);
    localparam logic [DLY_W-1:0] TO_LIM = DLY_W'(TIMEOUT_CYC - 1);

    sweep_st_t        st, nxt;
    logic [DLY_W-1:0] dwell_q, cur_ofs, lim;
    logic             hit, last_rep, at_zero, load, adv, add, tmo;

    // Phase sequencing.
    always_comb begin
        nxt = st;
        tmo = 1'b0;
        case (st)
            ST_IDLE:   if (start) nxt = ST_GND;
            ST_GND:    if (hit) nxt = ST_WAIT;
            ST_WAIT:   if (hit) nxt = ST_CONV;
            ST_CONV:   nxt = ST_DATA;
            ST_DATA: begin
                if (adc_valid)  nxt = last_rep ? ST_WRITE : ST_GND;
                else if (hit) begin
                    nxt = ST_FINISH;
                    tmo = 1'b1;
                end
            end
            ST_WRITE:  nxt = at_zero ? ST_FINISH : ST_GND;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Phase limit selection for the shared timer.
    always_comb begin
        case (st)
            ST_GND:  lim = dwell_q;
            ST_WAIT: lim = cur_ofs;
            default: lim = TO_LIM;
        endcase
    end

    // Control strobes to the datapath modules.
    always_comb begin
        load = (st == ST_IDLE) && start;
        adv  = (st == ST_WRITE) && !at_zero;
        add  = (st == ST_DATA) && adc_valid;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Dwell capture at start; ignored while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)    dwell_q <= '0;
        else if (load) dwell_q <= cfg_dwell;
    end

    // Error flag: set on data timeout, cleared by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)    err <= 1'b0;
        else if (load) err <= 1'b0;
        else if (tmo)  err <= 1'b1;
    end

    settle_timer #(.CNT_W(DLY_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((st != nxt) || (st == ST_IDLE)),
        .limit (lim),
        .hit   (hit)
    );

    settle_accum #(.DATA_W(DATA_W), .EXTRA_W(EXTRA_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load || (st == ST_WRITE)),
        .add      (add),
        .din      (adc_data),
        .last_rep (last_rep),
        .avg      (res_data)
    );

    settle_ofs_gen #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .cfg_ofs  (cfg_start_ofs),
        .cfg_step (cfg_step),
        .ofs      (cur_ofs),
        .idx      (res_addr),
        .at_zero  (at_zero)
    );

    // Output decode from the phase.
    always_comb begin
        mux_sel    = (st == ST_WAIT) || (st == ST_CONV) || (st == ST_DATA);
        adc_convst = (st == ST_CONV);
        res_we     = (st == ST_WRITE);
        busy       = (st != ST_IDLE);
        done       = (st == ST_FINISH);
    end
endmodule

// File: rtl/settle_sweep_chk.sv
// Protocol checker for settle_sweep_bist, attached by bind below.
module settle_sweep_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              mux_sel,
    input logic              adc_convst,
    input logic              res_we,
    input logic [ADDR_W-1:0] res_addr
);
    logic              seen_we;
    logic [ADDR_W-1:0] last_addr;

    // Track the previous write address within a sweep.
    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            seen_we   <= 1'b0;
            last_addr <= '0;
        end else if (res_we) begin
            seen_we   <= 1'b1;
            last_addr <= res_addr;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
    AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |=> !adc_convst); // R3
    AST_CONV_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |-> mux_sel); // R3
    AST_STEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |=> mux_sel); // R3
    AST_ADDR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && seen_we) |-> (res_addr == ADDR_W'(last_addr + 1'b1))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !res_we); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_convst && !res_we && !mux_sel && !done)); // R1
endmodule

bind settle_sweep_bist settle_sweep_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .mux_sel    (mux_sel),
    .adc_convst (adc_convst),
    .res_we     (res_we),
    .res_addr   (res_addr)
);

// File: tb/settle_sweep_bist_test.sv
module settle_sweep_bist_test;
    localparam int DATA_W = 16;
    localparam int W      = 2;
    localparam int DLY_W  = 16;
    localparam int ADDR_W = 8;
    localparam int TMO    = 16;
    localparam int REPS   = 1 << (2 * W);
    localparam int LAT    = 3;
    localparam int NVEC   = 4;
    // {start offset, step, dwell}
    localparam logic [47:0] VEC [0:NVEC-1] = '{
        {16'd20, 16'd2, 16'd4},
        {16'd7,  16'd3, 16'd2},
        {16'd0,  16'd5, 16'd3},
        {16'd5,  16'd0, 16'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, adc_valid = 1'b0;
    logic [DLY_W-1:0] cfg_start_ofs = '0, cfg_step = '0, cfg_dwell = '0;
    logic [DATA_W-1:0] adc_data = '0;
    logic mux_sel, adc_convst, res_we, busy, done, err;
    logic [ADDR_W-1:0] res_addr;
    logic [DATA_W+W-1:0] res_data;

    settle_sweep_bist #(.DATA_W(DATA_W), .EXTRA_W(W), .DLY_W(DLY_W),
                        .ADDR_W(ADDR_W), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_start_ofs(cfg_start_ofs),
        .cfg_step(cfg_step), .cfg_dwell(cfg_dwell), .adc_data(adc_data),
        .adc_valid(adc_valid), .mux_sel(mux_sel), .adc_convst(adc_convst),
        .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
        .busy(busy), .done(done), .err(err));

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, rise_cyc = 0, low_len = 1000, gap = 0, conv_in_pt = 0;
    int conv_total = 0, pend = 0, writes_seen = 0, last_we_cyc = -5, done_cyc = -1;
    int exp_ofs = 0, exp_step = 1, exp_dwell = 0, exp_idx = 0;
    int model_sum = 0;
    bit gap_bad = 0, low_bad = 0, mux_prev = 0, conv_prev = 0;
    bit adc_en = 1, stray_en = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int wave(input int o, input int k);
        return 20000 + o * 97 + (k % 5) * 3;
    endfunction

    function automatic int npoints(input int o, input int s);
        int n = 1;
        int ss = (s == 0) ? 1 : s;
        while (o != 0) begin
            o = (o >= ss) ? o - ss : 0;
            n++;
        end
        return n;
    endfunction

    // Port monitor and ADC model, both away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (mux_sel && !mux_prev) begin
                rise_cyc = cyc;
                if (low_len < exp_dwell + 1) low_bad = 1;
                low_len = 0;
            end
            if (!mux_sel) low_len++;
            if (adc_convst && !conv_prev) begin
                gap = cyc - rise_cyc;
                if (gap != exp_ofs + 1) gap_bad = 1;
                conv_in_pt++;
                if (adc_en) pend = LAT;
            end
            if (res_we) begin
                check(res_addr == ADDR_W'(exp_idx), "R6 result index", res_addr, exp_idx);
                check(res_data == (DATA_W+W)'(model_sum >> W), "R5 averaged value",
                      res_data, model_sum >> W);
                check(conv_in_pt == REPS, "R5 conversions per point", conv_in_pt, REPS);
                check(!gap_bad, "R4 step-to-convert gap", gap, exp_ofs + 1);
                check(!low_bad, "R3 ground dwell length", 0, exp_dwell + 1);
                exp_ofs = (exp_ofs >= exp_step) ? exp_ofs - exp_step : 0;
                exp_idx++;
                model_sum = 0;
                conv_in_pt = 0;
                gap_bad = 0;
                low_bad = 0;
                writes_seen++;
                last_we_cyc = cyc;
            end
            if (done) done_cyc = cyc;
            mux_prev = mux_sel;
            conv_prev = adc_convst;
            adc_valid = 1'b0;
            adc_data = '0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    adc_valid = 1'b1;
                    adc_data = DATA_W'(wave(gap - 1, conv_total));
                    model_sum += wave(gap - 1, conv_total);
                    conv_total++;
                end
            end else if (stray_en && !mux_sel) begin
                adc_valid = 1'b1;
                adc_data = 16'hFFFF;
            end
        end
    end

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 30000 && !got; i++) begin
            @(negedge clk);
            if (done) got = 1;
        end
    endtask

    task automatic run_sweep(input int so, input int st, input int dw, input bit disturb,
                             input bit expect_err);
        bit got;
        int np = npoints(so, st);
        exp_ofs = so; exp_step = (st == 0) ? 1 : st; exp_dwell = dw; exp_idx = 0;
        writes_seen = 0; gap_bad = 0; low_bad = 0; conv_in_pt = 0; model_sum = 0;
        done_cyc = -1;
        cfg_start_ofs = DLY_W'(so); cfg_step = DLY_W'(st); cfg_dwell = DLY_W'(dw);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(err == 1'b0, "R9 err cleared by start", err, 0);
        if (disturb) begin
            repeat (30) @(negedge clk);
            cfg_start_ofs = 16'd3; cfg_step = 16'd1; cfg_dwell = 16'd0;
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait_done(got);
        check(got, "R7 done reached (watchdog)", got, 1);
        if (expect_err) begin
            check(writes_seen == 0, "R9 aborted point not written", writes_seen, 0);
            check(err == 1'b1, "R9 err set on timeout", err, 1);
        end else begin
            check(writes_seen == np, disturb ? "R8 points unchanged by config" :
                  "R6 point count", writes_seen, np);
            check(done_cyc == last_we_cyc + 1, "R7 done after last write",
                  done_cyc - last_we_cyc, 1);
            check(err == 1'b0, "R9 no err on good sweep", err, 0);
        end
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R7 single done then idle", {done, busy}, 0);
    endtask

    // Global watchdog.
    initial begin
        #(20ns * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, err, res_we, adc_convst, mux_sel} == 6'b0,
              "R1 reset outputs", {busy, done, err, res_we, adc_convst, mux_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && mux_sel == 1'b0, "R1 idle after reset", {busy, mux_sel}, 0);

        // Table walk: offset sequences, dwell, gaps, averages.
        for (int i = 0; i < NVEC; i++)
            run_sweep(int'(VEC[i][47:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]), 0, 0);

        // R8: config changes and start pulses mid-sweep are ignored.
        run_sweep(12, 4, 3, 1, 0);

        // R10: stray valid strobes while on ground are ignored.
        stray_en = 1;
        run_sweep(6, 2, 2, 0, 0);
        stray_en = 0;

        // R9: ADC never answers.
        adc_en = 0;
        run_sweep(3, 1, 2, 0, 1);
        repeat (5) @(negedge clk);
        check(err == 1'b1, "R9 err holds while idle", err, 1);
        adc_en = 1;
        run_sweep(2, 1, 1, 0, 0);

        // R1: reset during a sweep returns to idle.
        cfg_start_ofs = 16'd30; cfg_step = 16'd1; cfg_dwell = 16'd2;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({busy, done, err, res_we, adc_convst, mux_sel} == 6'b0,
              "R1 reset mid-sweep", {busy, done, err, res_we, adc_convst, mux_sel}, 0);
        rst_n = 1'b1;
        pend = 0;
        repeat (2) @(negedge clk);
        run_sweep(4, 2, 1, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule